// File: doc/BRIEF.md
# Bus-Fed Accumulator ALU with Latched Operand

This block is the arithmetic and logic unit of a small processor built around one internal data bus. It has a single operand input from that bus. A two-operand operation takes two cycles. On the first cycle the bus value is captured into an internal B register. On a later cycle the bus value is taken as operand A and combined with B. The result and the zero and carry flags are registered on the rising clock edge of that execute cycle. Increment and decrement use only A and finish in one cycle.

The stored result goes back onto the bus only while the result output enable is high. The flags are never placed on the bus. They leave the block on two dedicated lines that the control logic uses for conditional jumps.

The carry input of the adder is the held carry flag. Two control lines can preset or clear that flag before an add or subtract. Only the arithmetic and shift operations write carry.

Every transfer finishes in the cycle it is issued, and the block never stalls, so its edge has no valid/ready handshake. The bus is a shared resource that the sequencer schedules. The strobes `load_b` and `exec` act as per-cycle valid qualifiers, and there is no back-pressure.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and after its release, the result register, the B register, the zero flag and the carry flag are all 0, and `bus_out` reads 0 even with `res_oe` high.
- R2: With `load_b` high, `bus_in` is captured into the B register at the rising edge. With `load_b` low, the B register keeps its value.
- R3: With `exec` high, the operation selected by `op` is applied to A = `bus_in` and the stored B, and the result is registered at that edge. The encodings are 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 NOT A, 6 shift left, 7 shift right, 8 increment, 9 decrement.
- R4: Add gives A + B + cin, where cin is the effective carry. The carry flag takes the carry out of bit 7.
- R5: Subtract gives A + ~B + cin. A carry flag of 1 afterwards means no borrow.
- R6: AND, OR, XOR and NOT update the result and the zero flag but leave the carry flag unchanged.
- R7: Shift left gives {A[6:0], cin} with carry = A[7]. Shift right gives {cin, A[7:1]} with carry = A[0].
- R8: Increment gives A + 1 and decrement gives A + 0xFF. Neither depends on the stored carry. Carry takes their carry out: 1 when incrementing 0xFF, and 1 when decrementing any nonzero value.
- R9: Every executed legal operation sets the zero flag when the 8-bit result is 0 and clears it otherwise.
- R10: The effective carry is 0 when `carry_clr` is high, otherwise 1 when `carry_set` is high, otherwise the held flag. `carry_clr` wins over `carry_set`. A set or clear in the same cycle as `exec` supplies that operation's carry-in. A carry-writing operation's carry out overrides the set or clear. With no carry-writing operation, the flag takes the effective carry.
- R11: `bus_out` equals the result register while `res_oe` is high and is all zeros while it is low.
- R12: `exec` with `op` from 10 to 15 changes neither the result nor the zero flag. A set or clear in that cycle still applies to carry.
- R13: When `load_b` and `exec` are high in the same cycle, the operation uses the B value held before that edge, and B then takes the new bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 8 | Internal data bus value (operand A or B) |
| load_b | input | 1 | Capture bus_in into the B register |
| exec | input | 1 | Execute the operation in op this cycle |
| op | input | 4 | Operation code, valid with exec |
| carry_set | input | 1 | Preset the carry to 1 |
| carry_clr | input | 1 | Clear the carry to 0 (wins over set) |
| res_oe | input | 1 | Drive the stored result onto bus_out |
| bus_out | output | 8 | Gated result toward the data bus |
| zero_flag | output | 1 | Zero flag to control logic |
| carry_flag | output | 1 | Carry flag to control logic |

## Verification
Two functions can fall in the same cycle. A carry set or clear can coincide with an executed operation, and a B load can coincide with an execute. The bench provokes both by raising those inputs together on one cycle, for example a set with an add whose held carry is 0, a clear with an AND, both set and clear together, and a load of a new B during a subtract. The checks compare the result and flags with the outcome that R10 and R13 prescribe: the set or clear is the carry-in, the operation's carry out takes precedence, and the operation uses the old B.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOT = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    SEL_ADD,
    SEL_AND,
    SEL_OR,
    SEL_XOR,
    SEL_NOT,
    SEL_SHL,
    SEL_SHR
  } res_sel_e;

  typedef struct packed {
    logic     legal;     // opcode is defined
    logic     b_en;      // pass stored B (else zeros)
    logic     b_inv;     // invert B path bitwise
    logic     cin_force; // adder carry-in from decode, not the flag
    logic     cin_val;   // forced carry-in value
    logic     carry_wr;  // operation writes the carry flag
    res_sel_e sel;       // result source
  } ctl_t;

endpackage

// File: rtl/alu_opdecode.sv
module alu_opdecode
  import alu_pkg::*;
(
  input  logic [3:0] op,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{legal: 1'b1, b_en: 1'b1, b_inv: 1'b0, cin_force: 1'b0,
            cin_val: 1'b0, carry_wr: 1'b0, sel: SEL_ADD};
    case (op)
      OP_ADD: ctl.carry_wr = 1'b1;
      OP_SUB: begin
        ctl.b_inv    = 1'b1;
        ctl.carry_wr = 1'b1;
      end
      OP_AND: ctl.sel = SEL_AND;
      OP_OR:  ctl.sel = SEL_OR;
      OP_XOR: ctl.sel = SEL_XOR;
      OP_NOT: ctl.sel = SEL_NOT;
      OP_SHL: begin
        ctl.sel      = SEL_SHL;
        ctl.carry_wr = 1'b1;
      end
      OP_SHR: begin
        ctl.sel      = SEL_SHR;
        ctl.carry_wr = 1'b1;
      end
      OP_INC: begin
        ctl.b_en      = 1'b0;
        ctl.cin_force = 1'b1;
        ctl.cin_val   = 1'b1;
        ctl.carry_wr  = 1'b1;
      end
      OP_DEC: begin
        ctl.b_en      = 1'b0;
        ctl.b_inv     = 1'b1;
        ctl.cin_force = 1'b1;
        ctl.cin_val   = 1'b0;
        ctl.carry_wr  = 1'b1;
      end
      default: ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_bpath.sv
module alu_bpath #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_q,
  input  logic         b_en,
  input  logic         b_inv,
  output logic [W-1:0] b_eff
);

  // Per-bit gate followed by a controllable inverter (XOR).
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_eff[i] = (b_q[i] & b_en) ^ b_inv;
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] total;

  assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum   = total[W-1:0];
  assign cout  = total[W];

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         right,
  output logic [W-1:0] res,
  output logic         cout
);

  always_comb begin
    if (right) begin
      res  = {cin, a[W-1:1]};
      cout = a[0];
    end else begin
      res  = {a[W-2:0], cin};
      cout = a[W-1];
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_in,
  input  logic         load_b,
  input  logic         exec,
  input  logic [3:0]   op,
  input  logic         carry_set,
  input  logic         carry_clr,
  input  logic         res_oe,
  output logic [W-1:0] bus_out,
  output logic         zero_flag,
  output logic         carry_flag
);

  logic [W-1:0] b_q, res_q, b_eff, sum, sh_res, res_d;
  logic         carry_q, zero_q, cin_eff, add_cin, add_cout, sh_cout, cout_d;
  ctl_t         ctl;

  // Effective carry: clear wins over set, otherwise the held flag.
  assign cin_eff = carry_clr ? 1'b0 : (carry_set ? 1'b1 : carry_q);
  assign add_cin = ctl.cin_force ? ctl.cin_val : cin_eff;

  alu_opdecode u_dec (.op(op), .ctl(ctl));

  alu_bpath #(.W(W)) u_bpath (
    .b_q(b_q), .b_en(ctl.b_en), .b_inv(ctl.b_inv), .b_eff(b_eff)
  );

  alu_adder #(.W(W)) u_add (
    .a(bus_in), .b(b_eff), .cin(add_cin), .sum(sum), .cout(add_cout)
  );

  alu_shift #(.W(W)) u_shift (
    .a(bus_in), .cin(cin_eff), .right(ctl.sel == SEL_SHR),
    .res(sh_res), .cout(sh_cout)
  );

  always_comb begin
    cout_d = add_cout;
    case (ctl.sel)
      SEL_AND: res_d = bus_in & b_q;
      SEL_OR:  res_d = bus_in | b_q;
      SEL_XOR: res_d = bus_in ^ b_q;
      SEL_NOT: res_d = ~bus_in;
      SEL_SHL, SEL_SHR: begin
        res_d  = sh_res;
        cout_d = sh_cout;
      end
      default: res_d = sum;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q     <= '0;
      res_q   <= '0;
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (load_b) b_q <= bus_in;
      if (exec && ctl.legal) begin
        res_q   <= res_d;
        zero_q  <= (res_d == '0);
        carry_q <= ctl.carry_wr ? cout_d : cin_eff;
      end else begin
        carry_q <= cin_eff;
      end
    end
  end

  assign bus_out    = res_oe ? res_q : '0;
  assign zero_flag  = zero_q;
  assign carry_flag = carry_q;

endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_in,
  input logic         load_b,
  input logic         exec,
  input logic [3:0]   op,
  input logic         carry_set,
  input logic         carry_clr,
  input logic [W-1:0] b_q,
  input logic [W-1:0] res_q,
  input logic         zero_flag,
  input logic         carry_flag
);

  logic legal_op, logic_op, carry_op;
  assign legal_op = (op <= 4'd9);
  assign logic_op = (op >= 4'd2) && (op <= 4'd5);
  assign carry_op = legal_op && !logic_op;

  assert_b_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> b_q == $past(bus_in));

  assert_b_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_b |=> $stable(b_q));

  assert_logic_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && logic_op && !carry_set && !carry_clr) |=> $stable(carry_flag));

  assert_inc_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 4'd8) |=> res_q == W'($past(bus_in) + 1'b1));

  assert_zero_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && legal_op) |=> zero_flag == (res_q == '0));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_clr && !(exec && carry_op)) |=> !carry_flag);

  assert_no_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && legal_op) |=> ($stable(res_q) && $stable(zero_flag)));

endmodule

bind acc_alu alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_b(load_b), .exec(exec),
  .op(op), .carry_set(carry_set), .carry_clr(carry_clr), .b_q(b_q),
  .res_q(res_q), .zero_flag(zero_flag), .carry_flag(carry_flag)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = '0;
  logic       load_b = 1'b0, exec = 1'b0, carry_set = 1'b0, carry_clr = 1'b0;
  logic       res_oe = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] bus_out;
  logic       zero_flag, carry_flag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_b = '0, m_res = '0;
  logic       m_z = 1'b0, m_c = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  acc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .load_b(load_b), .exec(exec),
    .op(op), .carry_set(carry_set), .carry_clr(carry_clr), .res_oe(res_oe),
    .bus_out(bus_out), .zero_flag(zero_flag), .carry_flag(carry_flag)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // One cycle of stimulus; model update; checks of result and both flags.
  task automatic step(string req, bit ld, bit ex, logic [3:0] opc,
                      logic [7:0] val, bit cs, bit cc);
    logic       cin, co, wc;
    logic [7:0] r;
    logic [8:0] t;
    @(negedge clk);
    bus_in = val; load_b = ld; exec = ex; op = opc;
    carry_set = cs; carry_clr = cc; res_oe = 1'b0;
    cin = cc ? 1'b0 : (cs ? 1'b1 : m_c);
    if (ex && opc <= 4'd9) begin
      wc = 1'b1; co = 1'b0; r = '0;
      case (opc)
        4'd0: begin t = {1'b0, val} + {1'b0, m_b} + {8'd0, cin}; r = t[7:0]; co = t[8]; end
        4'd1: begin t = {1'b0, val} + {1'b0, ~m_b} + {8'd0, cin}; r = t[7:0]; co = t[8]; end
        4'd2: begin r = val & m_b; wc = 1'b0; end
        4'd3: begin r = val | m_b; wc = 1'b0; end
        4'd4: begin r = val ^ m_b; wc = 1'b0; end
        4'd5: begin r = ~val; wc = 1'b0; end
        4'd6: begin r = {val[6:0], cin}; co = val[7]; end
        4'd7: begin r = {cin, val[7:1]}; co = val[0]; end
        4'd8: begin t = {1'b0, val} + 9'd1; r = t[7:0]; co = t[8]; end
        default: begin t = {1'b0, val} + 9'h0FF; r = t[7:0]; co = t[8]; end
      endcase
      m_res = r;
      m_z = (r == 8'd0);
      m_c = wc ? co : cin;
    end else begin
      m_c = cin;
    end
    if (ld) m_b = val;
    @(negedge clk);
    load_b = 1'b0; exec = 1'b0; carry_set = 1'b0; carry_clr = 1'b0;
    res_oe = 1'b1;
    #1;
    check({req, " result"}, bus_out, m_res);
    check({req, " zero"}, {7'd0, zero_flag}, {7'd0, m_z});
    check({req, " carry"}, {7'd0, carry_flag}, {7'd0, m_c});
    res_oe = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    res_oe = 1'b1; #1;
    check("R1 reset bus", bus_out, 8'h00);
    check("R1 reset zero", {7'd0, zero_flag}, 8'h00);
    check("R1 reset carry", {7'd0, carry_flag}, 8'h00);
    res_oe = 1'b0;
    rst_n = 1'b1;
    // B is 0 after reset: OR with 0 returns A
    step("R1 reset B", 0, 1, 4'd3, 8'h5A, 0, 0);
  endtask

  task automatic t_add();
    step("R2 load", 1, 0, 4'd0, 8'h3C, 0, 1);
    step("R4 add", 0, 1, 4'd0, 8'h05, 0, 0);
    step("R2 load", 1, 0, 4'd0, 8'h20, 0, 0);
    step("R4 add carry out", 0, 1, 4'd0, 8'hF0, 0, 0);
    step("R4 add with cin", 0, 1, 4'd0, 8'h01, 0, 0);
    step("R2 hold B", 0, 1, 4'd0, 8'h00, 0, 1);
  endtask

  task automatic t_sub();
    step("R2 load", 1, 0, 4'd0, 8'h10, 0, 0);
    step("R5 sub no borrow", 0, 1, 4'd1, 8'h30, 1, 0);
    step("R5 sub borrow", 0, 1, 4'd1, 8'h05, 1, 0);
    step("R5 sub to zero", 0, 1, 4'd1, 8'h10, 1, 0);
    step("R5 sub borrow-in", 0, 1, 4'd1, 8'h30, 0, 1);
  endtask

  task automatic t_logic();
    step("R2 load", 1, 0, 4'd0, 8'hF0, 1, 0);
    step("R6 and", 0, 1, 4'd2, 8'h3C, 0, 0);
    step("R6 or", 0, 1, 4'd3, 8'h0F, 0, 0);
    step("R6 xor", 0, 1, 4'd4, 8'hF0, 0, 0);
    step("R6 not", 0, 1, 4'd5, 8'hFF, 0, 0);
    step("R6 carry0 and", 0, 1, 4'd2, 8'hFF, 0, 1);
    step("R6 keep carry0", 0, 1, 4'd4, 8'h0F, 0, 0);
  endtask

  task automatic t_shift();
    step("R7 shl", 0, 1, 4'd6, 8'h81, 1, 0);
    step("R7 shl carry", 0, 1, 4'd6, 8'h40, 0, 0);
    step("R7 shr", 0, 1, 4'd7, 8'h01, 0, 1);
    step("R7 shr cin", 0, 1, 4'd7, 8'h80, 1, 0);
  endtask

  task automatic t_incdec();
    step("R8 inc ignores carry", 0, 1, 4'd8, 8'h10, 1, 0);
    step("R8 inc wrap", 0, 1, 4'd8, 8'hFF, 0, 0);
    step("R8 dec from 0", 0, 1, 4'd9, 8'h00, 1, 0);
    step("R8 dec to 0", 0, 1, 4'd9, 8'h01, 0, 1);
    step("R9 zero clears", 0, 1, 4'd8, 8'h7F, 0, 0);
  endtask

  task automatic t_collide();
    step("R2 load", 1, 0, 4'd0, 8'h01, 0, 1);
    step("R10 set with add", 0, 1, 4'd0, 8'h01, 1, 0);
    step("R10 clr with and", 0, 1, 4'd2, 8'h01, 0, 1);
    step("R10 set with or", 0, 1, 4'd3, 8'h02, 1, 0);
    step("R10 set and clr", 0, 1, 4'd0, 8'h01, 1, 1);
    step("R10 set then cout", 0, 1, 4'd0, 8'h02, 1, 0);
    step("R13 load with sub", 1, 1, 4'd1, 8'h09, 1, 0);
    step("R13 new B used", 0, 1, 4'd1, 8'h09, 1, 0);
  endtask

  task automatic t_illegal();
    step("R3 setup", 0, 1, 4'd8, 8'h41, 0, 0);
    step("R12 op12 no change", 0, 1, 4'd12, 8'h00, 0, 0);
    step("R12 op15 carry set", 0, 1, 4'd15, 8'hFF, 1, 0);
    step("R3 idle no exec", 0, 0, 4'd0, 8'h00, 0, 0);
  endtask

  task automatic t_oe();
    @(negedge clk);
    res_oe = 1'b0; #1;
    check("R11 oe low", bus_out, 8'h00);
    res_oe = 1'b1; #1;
    check("R11 oe high", bus_out, m_res);
    res_oe = 1'b0;
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_incdec();
    t_collide();
    t_illegal();
    t_oe();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule